// File: doc/BRIEF.md
# Alarm Status Latch and Mask

This block sits between a set of fault detectors and a host. Each detector raises one fault line that is synchronous to the block clock. The block keeps one status bit per source. A fault always sets its status bit. A per-source enable decides only whether that status bit may pull the shared active-low alarm pin. A global pin-enable input gates the pin as a whole.

A small control register holds the per-source enables and a latch-disable bit. Its lowest bits are reserved. With latching on, a status bit survives the end of its fault and clears only on a status read that finds the fault gone. With latching off, each bit simply tracks its fault one clock later. The host reads the status word while pulsing a read strobe. The word it sees in that cycle is the value from before any clear the read causes.

Top module: `alarm_latch_top`

## Requirements
- R1: After reset the status word is 0, the control register reads 0 and the alarm pin is high.
- R2: Control layout: bit 4 enables source 0, bit 3 enables source 1 and bit 2 is latch-disable. A write stores these bits, and they read back at the same positions on the next cycle.
- R3: The lowest two control bits (1 and 0) are reserved. Writing them changes nothing, and they always read 0.
- R4: A fault on a source sets its status bit on the next clock, whatever that source's enable bit says.
- R5: With latch-disable at 0 and no status read, a set status bit stays 1 even after its fault goes away.
- R6: With latch-disable at 0, a status read clears a bit on the next clock only if its fault is absent in the read cycle. A read while the fault is present, or in the same cycle the fault returns, leaves the bit at 1.
- R7: During the cycle of a status read, the status output still shows the bits as they were before any clear that the read causes.
- R8: With latch-disable at 1, each status bit equals its fault input from the previous cycle, whether or not the register is read.
- R9: When latch-disable changes from 0 to 1, a latched bit whose fault is already gone clears on the next clock.
- R10: The alarm pin is low exactly when pin-enable is 1 and some source has both its status bit and its enable bit at 1. Otherwise it is high. In the default build the pin is combinational from the status, the control register and pin-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | NSRC | Fault lines, bit i for source i |
| pin_en_i | input | 1 | Global enable for the alarm pin |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | CTRL_W | Control register write data |
| ctl_rdata_o | output | CTRL_W | Control register read value |
| stat_rd_i | input | 1 | Status register read strobe |
| stat_o | output | NSRC | Status bits, bit i for source i |
| alarm_n_o | output | 1 | Shared active-low alarm pin |

## Verification
The bench uses the defaults: two sources, two reserved bits and an unregistered pin. This gives the 5-bit control layout of R2 and R3. At this size, random stimulus often reaches every mix of fault, read strobe, enable and latch mode. That includes the rare case where a fault returns in the same cycle as the read that would clear it, and a change of latch mode while a stale bit is held. Directed steps pin those cases down before the random phase begins.

// File: rtl/alarm_pkg.sv
`timescale 1ns/1ps
package alarm_pkg;
   // Width of the control word: reserved bits, latch-disable, then enables.
   function automatic int ctrl_width(input int nsrc, input int rsv);
      return rsv + 1 + nsrc;
   endfunction
endpackage

// File: rtl/alarm_ctrl_reg.sv
`timescale 1ns/1ps
module alarm_ctrl_reg #(
   parameter int NSRC   = 2,
   parameter int RSV_W  = 2,
   localparam int CTRL_W = alarm_pkg::ctrl_width(NSRC, RSV_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [CTRL_W-1:0] wdata_i,
   output logic [NSRC-1:0]   en_o,
   output logic              ld_o,
   output logic [CTRL_W-1:0] rdata_o
);
   localparam int LD_POS = RSV_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_o <= 1'b0;
      end else if (we_i) begin
         ld_o <= wdata_i[LD_POS];
      end
   end

   // Source i sits at the top of the word going downwards.
   for (genvar i = 0; i < NSRC; i++) begin : g_en
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_o[i] <= 1'b0;
         end else if (we_i) begin
            en_o[i] <= wdata_i[CTRL_W-1-i];
         end
      end
      assign rdata_o[CTRL_W-1-i] = en_o[i];
   end

   assign rdata_o[LD_POS] = ld_o;

   if (RSV_W > 0) begin : g_rsv
      assign rdata_o[RSV_W-1:0] = '0;
   end
endmodule

// File: rtl/alarm_stat_bit.sv
`timescale 1ns/1ps
module alarm_stat_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic fault_i,
   input  logic rd_i,
   input  logic ld_i,
   output logic stat_o
);
   logic nxt;

   always_comb begin
      if (ld_i) begin
         nxt = fault_i;
      end else begin
         // Held until a read finds the fault gone; a live fault wins.
         nxt = fault_i | (stat_o & ~rd_i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_o <= 1'b0;
      end else begin
         stat_o <= nxt;
      end
   end
endmodule

// File: rtl/alarm_pin_drv.sv
`timescale 1ns/1ps
module alarm_pin_drv #(
   parameter int NSRC    = 2,
   parameter bit PIN_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] stat_i,
   input  logic [NSRC-1:0] en_i,
   input  logic            pin_en_i,
   output logic            alarm_n_o
);
   logic active;

   assign active = pin_en_i & (|(stat_i & en_i));

   if (PIN_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            alarm_n_o <= 1'b1;
         end else begin
            alarm_n_o <= ~active;
         end
      end
   end else begin : g_comb
      assign alarm_n_o = ~active;
   end
endmodule

// File: rtl/alarm_latch_top.sv
`timescale 1ns/1ps
module alarm_latch_top #(
   parameter int NSRC    = 2,
   parameter int RSV_W   = 2,
   parameter bit PIN_REG = 1'b0,
   localparam int CTRL_W = alarm_pkg::ctrl_width(NSRC, RSV_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   fault_i,
   input  logic              pin_en_i,
   input  logic              ctl_we_i,
   input  logic [CTRL_W-1:0] ctl_wdata_i,
   output logic [CTRL_W-1:0] ctl_rdata_o,
   input  logic              stat_rd_i,
   output logic [NSRC-1:0]   stat_o,
   output logic              alarm_n_o
);
   if (NSRC < 1) begin : g_bad_nsrc
      $error("alarm_latch_top: NSRC must be at least 1");
   end
   if (RSV_W < 0) begin : g_bad_rsv
      $error("alarm_latch_top: RSV_W must not be negative");
   end

   logic [NSRC-1:0] en;
   logic            ld;

   alarm_ctrl_reg #(.NSRC(NSRC), .RSV_W(RSV_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (ctl_we_i),
      .wdata_i (ctl_wdata_i),
      .en_o    (en),
      .ld_o    (ld),
      .rdata_o (ctl_rdata_o)
   );

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      alarm_stat_bit u_bit (
         .clk     (clk),
         .rst_n   (rst_n),
         .fault_i (fault_i[i]),
         .rd_i    (stat_rd_i),
         .ld_i    (ld),
         .stat_o  (stat_o[i])
      );
   end

   alarm_pin_drv #(.NSRC(NSRC), .PIN_REG(PIN_REG)) u_pin (
      .clk       (clk),
      .rst_n     (rst_n),
      .stat_i    (stat_o),
      .en_i      (en),
      .pin_en_i  (pin_en_i),
      .alarm_n_o (alarm_n_o)
   );
endmodule

// File: rtl/alarm_latch_chk.sv
`timescale 1ns/1ps
module alarm_latch_chk #(
   parameter int NSRC    = 2,
   parameter int RSV_W   = 2,
   parameter bit PIN_REG = 1'b0,
   localparam int CTRL_W = alarm_pkg::ctrl_width(NSRC, RSV_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NSRC-1:0]   fault_i,
   input logic              pin_en_i,
   input logic              ctl_we_i,
   input logic [CTRL_W-1:0] ctl_wdata_i,
   input logic [CTRL_W-1:0] ctl_rdata_o,
   input logic              stat_rd_i,
   input logic [NSRC-1:0]   stat_o,
   input logic              alarm_n_o
);
   logic [NSRC-1:0] en_seen;
   logic            ld_seen;

   always_comb begin
      for (int i = 0; i < NSRC; i++) begin
         en_seen[i] = ctl_rdata_o[CTRL_W-1-i];
      end
   end
   assign ld_seen = ctl_rdata_o[RSV_W];

   // R2: a write is visible on the read port next cycle
   a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we_i |=> ctl_rdata_o[CTRL_W-1:RSV_W] == $past(ctl_wdata_i[CTRL_W-1:RSV_W]));

   // R4: every present fault is reflected in status next cycle
   a_r4_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (stat_o & $past(fault_i)) == $past(fault_i));

   // R5: latched bits survive while nobody reads
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_seen && !stat_rd_i) |=> (stat_o & $past(stat_o)) == $past(stat_o));

   // R6: a latched read leaves exactly the bits whose fault is live
   a_r6_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_seen && stat_rd_i) |=> stat_o == $past(fault_i));

   // R8: transparent mode follows the fault lines
   a_r8_follow: assert property (@(posedge clk) disable iff (!rst_n)
      ld_seen |=> stat_o == $past(fault_i));

   if (!PIN_REG) begin : g_pin_chk
      // R10: pin stays high when gated or when no enabled bit is set
      a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
         !pin_en_i |-> alarm_n_o);
      a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
         ((stat_o & en_seen) == '0) |-> alarm_n_o);
   end
endmodule

bind alarm_latch_top alarm_latch_chk #(.NSRC(NSRC), .RSV_W(RSV_W), .PIN_REG(PIN_REG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fault_i     (fault_i),
   .pin_en_i    (pin_en_i),
   .ctl_we_i    (ctl_we_i),
   .ctl_wdata_i (ctl_wdata_i),
   .ctl_rdata_o (ctl_rdata_o),
   .stat_rd_i   (stat_rd_i),
   .stat_o      (stat_o),
   .alarm_n_o   (alarm_n_o)
);

// File: tb/sim_alarm_latch_top.sv
`timescale 1ns/1ps
module sim_alarm_latch_top;
   localparam int NSRC   = 2;
   localparam int RSV_W  = 2;
   localparam int CTRL_W = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NSRC-1:0]   fault_i = '0;
   logic              pin_en_i = 1'b0;
   logic              ctl_we_i = 1'b0;
   logic [CTRL_W-1:0] ctl_wdata_i = '0;
   logic [CTRL_W-1:0] ctl_rdata_o;
   logic              stat_rd_i = 1'b0;
   logic [NSRC-1:0]   stat_o;
   logic              alarm_n_o;

   int checks = 0;
   int errors = 0;

   logic [1:0] m_stat = '0;
   logic [4:0] m_ctrl = '0;

   always #2.5 clk = ~clk;

   alarm_latch_top u0 (
      .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .pin_en_i(pin_en_i),
      .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i), .ctl_rdata_o(ctl_rdata_o),
      .stat_rd_i(stat_rd_i), .stat_o(stat_o), .alarm_n_o(alarm_n_o)
   );

   function automatic logic [1:0] nxt_stat(input logic [1:0] s, input logic [1:0] f,
                                           input logic rd, input logic ld);
      return ld ? f : (f | (s & ~{2{rd}}));
   endfunction

   function automatic logic [4:0] nxt_ctrl(input logic [4:0] c, input logic we,
                                           input logic [4:0] wd);
      return we ? {wd[4:2], 2'b00} : c;
   endfunction

   function automatic logic exp_pin(input logic [1:0] s, input logic [4:0] c, input logic pe);
      logic [1:0] en;
      en = {c[3], c[4]};
      return !(pe && ((s & en) != 2'b00));
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Drive one cycle of inputs, check outputs, advance the model.
   task automatic cyc(input logic [1:0] f, input logic pe, input logic we,
                      input logic [4:0] wd, input logic rd,
                      input string ts, input string tc, input string tp);
      @(negedge clk);
      fault_i = f; pin_en_i = pe; ctl_we_i = we; ctl_wdata_i = wd; stat_rd_i = rd;
      #1;
      chk(ts, int'(stat_o), int'(m_stat));
      chk(tc, int'(ctl_rdata_o), int'(m_ctrl));
      chk(tp, int'(alarm_n_o), int'(exp_pin(m_stat, m_ctrl, pe)));
      m_stat = nxt_stat(m_stat, f, rd, m_ctrl[2]);
      m_ctrl = nxt_ctrl(m_ctrl, we, wd);
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      chk("R1 status", int'(stat_o), 0);
      chk("R1 ctrl", int'(ctl_rdata_o), 0);
      chk("R1 pin", int'(alarm_n_o), 1);
      @(negedge clk);
      rst_n = 1'b1;

      // R3: write all ones, reserved bits must read 0
      cyc(2'b00, 1'b1, 1'b1, 5'b11111, 1'b0, "R1", "R1", "R1");
      cyc(2'b00, 1'b1, 1'b1, 5'b00011, 1'b0, "R1", "R2 R3", "R10");
      // R4: masked fault still sets status, pin stays high (R10)
      cyc(2'b01, 1'b1, 1'b0, 5'b0, 1'b0, "R4", "R3", "R10");
      cyc(2'b00, 1'b1, 1'b0, 5'b0, 1'b0, "R4", "R3", "R10");
      // R5: fault gone, no read, bit held
      cyc(2'b00, 1'b1, 1'b0, 5'b0, 1'b0, "R5", "R2", "R10");
      // R7: read cycle still shows the set bit
      cyc(2'b00, 1'b1, 1'b0, 5'b0, 1'b1, "R7", "R2", "R10");
      // R6: cleared after read with fault gone
      cyc(2'b10, 1'b1, 1'b0, 5'b0, 1'b0, "R6", "R2", "R10");
      // R6: read while fault present keeps bit
      cyc(2'b10, 1'b1, 1'b0, 5'b0, 1'b1, "R6", "R2", "R10");
      cyc(2'b00, 1'b1, 1'b0, 5'b0, 1'b0, "R6", "R2", "R10");
      // R6: fault returns in the read cycle, bit stays
      cyc(2'b10, 1'b1, 1'b0, 5'b0, 1'b1, "R6", "R2", "R10");
      cyc(2'b00, 1'b1, 1'b1, 5'b01000, 1'b0, "R6", "R2", "R10");
      // R10: source 1 enabled, status set, pin low
      cyc(2'b00, 1'b1, 1'b0, 5'b0, 1'b0, "R5", "R2", "R10");
      cyc(2'b00, 1'b0, 1'b0, 5'b0, 1'b0, "R5", "R2", "R10");
      // R9: switch to transparent with stale bit
      cyc(2'b00, 1'b1, 1'b1, 5'b01100, 1'b0, "R9", "R2", "R10");
      cyc(2'b00, 1'b1, 1'b0, 5'b0, 1'b0, "R9", "R2", "R10");
      // R8: follow mode
      cyc(2'b11, 1'b1, 1'b0, 5'b0, 1'b0, "R8", "R2", "R10");
      cyc(2'b00, 1'b1, 1'b0, 5'b0, 1'b0, "R8", "R2", "R10");
      cyc(2'b00, 1'b1, 1'b0, 5'b0, 1'b0, "R8", "R2", "R10");
      chk("R8 cleared", int'(stat_o), 0);

      for (int n = 0; n < 4000; n++) begin
         logic [1:0] f;
         logic       we;
         logic [4:0] wd;
         f  = 2'($urandom_range(0, 3));
         we = ($urandom_range(0, 9) == 0);
         wd = 5'($urandom);
         cyc(f, 1'($urandom), we, wd, ($urandom_range(0, 3) == 0),
             m_ctrl[2] ? "R8" : "R5", "R3", "R10");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule